// File: doc/BRIEF.md
# Change-Only Timestamped Sample Packer

This block turns a stream of 16-channel logic samples into compressed clusters for a row-organised sample memory. A sample is taken on every cycle where `tick_i` is high. While the channel levels stay the same, nothing is written. A level change opens a cluster. The cluster is one timestamp word followed by seven event words. The first event is the sample that opened the cluster. The other six are the samples of the next six ticks, stored whether they change or not. A reader rebuilds the full waveform from this: event k of a cluster belongs to tick "timestamp + k", and gaps between clusters mean the levels held.

The timestamp is a free-running tick count of `TS_W` bits. A quiet input must not hide a wrap of that count. So the packer opens a cluster even without a change once `2^TS_W - 1` ticks have passed since the last cluster opened. Two successive cluster timestamps therefore never differ by a full wrap. The first tick after reset always opens a cluster.

Each output word comes with a flat word address. Its upper `ROW_W` bits are the row and its lower bits are the word within the row. A row holds `CL_PER_ROW` clusters of eight words each, and `CL_PER_ROW` must be a power of two. With the defaults, a row is 512 words (1024 bytes, 448 events) and the address is 24 bits wide.

A small state machine controls each cluster:

- `ST_IDLE`: no cluster is open.
- `ST_STAMP`: the timestamp word has just been issued.
- `ST_FILL`: the remaining event slots are being filled.

It has these transitions:

- *open*: `ST_IDLE` to `ST_STAMP`, on a tick with a change or a due forced cluster.
- *first event*: `ST_STAMP` to `ST_FILL`, always after one cycle.
- *close*: `ST_FILL` to `ST_IDLE`, on the tick that fills the seventh slot.

Top module: `delta_cluster_packer`

## Requirements
- R1: Every cluster is eight consecutive writes: the timestamp word first, then seven event words. The timestamp word always lands at an address whose three low bits are 0.
- R2: In `ST_IDLE`, a tick whose sample differs from the previous tick's sample opens a cluster. The previous sample is 0 after reset. The timestamp word is presented in the cycle after the tick, and the first event (that tick's sample) in the cycle after that.
- R3: The timestamp value is the number of ticks seen since reset before the opening tick, modulo `2^TS_W`, zero-extended to 16 bits. It is stored low byte first: `wr_data_o[15:8]` = timestamp bits 7..0 and `wr_data_o[7:0]` = timestamp bits 15..8.
- R4: An event word carries the sample high byte first: `wr_data_o[15:8]` = channels 15..8 and `wr_data_o[7:0]` = channels 7..0.
- R5: After the first event, each of the next six ticks writes its own sample one cycle after the tick, changed or not. The cluster then closes.
- R6: In `ST_IDLE`, a tick whose sample equals the previous sample, with no forced cluster due, writes nothing. No write ever occurs without a cause from R2, R5 or R7.
- R7: In `ST_IDLE`, a tick opens a cluster without any change once `2^TS_W - 1` ticks have passed since the last opening tick. The first tick after reset always opens a cluster.
- R8: The write address is 0 at reset and each write uses the address after the previous one. After the last word of the last row, it wraps back to 0.
- R9: `wrap_o` is 0 from reset. It goes to 1 in the cycle that presents the write to the last address. It stays 1 until reset.
- R10: Ticks may come as often as every second cycle, and no sample is lost at that rate. A tick in the cycle right after an opening tick is outside the contract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample strobe; at least one idle cycle between strobes |
| sample_i | input | 16 | Channel levels taken when `tick_i` is high |
| wr_en_o | output | 1 | Memory word write strobe |
| wr_addr_o | output | ROW_W + log2(8*CL_PER_ROW) | Word address: row in upper bits, word in row in lower bits |
| wr_data_o | output | 16 | Timestamp or event word |
| wrap_o | output | 1 | Sticky flag: memory address space has wrapped |

## Verification
A corrupt slot counter moves the next timestamp word off an eight-word boundary. This shows as an address or data mismatch within the following cluster, so at most eight writes later. A wrong previous-sample register or gap counter shows as an extra or missing write one cycle after the tick concerned. For the gap counter, the error appears at the latest when the next forced cluster falls due, which is within `2^TS_W` ticks. A broken timestamp counter or byte swap corrupts the very first timestamp word after reset. An address counter fault shows on the next write, and a wrong wrap flag shows in the cycle of the last-address write.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    localparam int WORD_BITS          = 16;
    localparam int EVENTS_PER_CLUSTER = 7;
    localparam int WORDS_PER_CLUSTER  = EVENTS_PER_CLUSTER + 1;
    localparam int SLOT_W             = $clog2(WORDS_PER_CLUSTER);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STAMP = 2'd1,
        ST_FILL  = 2'd2
    } pk_state_e;

    // Timestamp is laid down low byte first in the 16-bit memory word.
    function automatic logic [WORD_BITS-1:0] stamp_word(input logic [WORD_BITS-1:0] ts);
        return {ts[7:0], ts[15:8]};
    endfunction

endpackage

// File: rtl/dcp_change_det.sv
module dcp_change_det #(
    parameter int GAP_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic [15:0] sample_i,
    input  logic        opened_i,
    output logic        want_open_o
);
    localparam logic [GAP_W-1:0] GAP_LIMIT = '1;

    logic [15:0]      prev_q;
    logic [GAP_W-1:0] gap_q;

    assign want_open_o = tick_i && ((sample_i != prev_q) || (gap_q == GAP_LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            gap_q  <= GAP_LIMIT;
        end else if (tick_i) begin
            prev_q <= sample_i;
            if (opened_i)
                gap_q <= GAP_W'(1);
            else if (gap_q != GAP_LIMIT)
                gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R7: the distance counter restarts on every opening tick
    p_gap_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && opened_i) |=> (gap_q == GAP_W'(1)));

    // R2: the previous-sample register only moves on a tick
    p_prev_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(prev_q));

endmodule

// File: rtl/dcp_tick_stamp.sv
module dcp_tick_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    output logic [TS_W-1:0] ts_o
);
    logic [TS_W-1:0] ts_q;

    assign ts_o = ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ts_q <= '0;
        else if (tick_i)
            ts_q <= ts_q + TS_W'(1);
    end

    // R3: the count advances by exactly one per tick and holds otherwise
    p_stamp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (ts_o == $past(ts_o) + TS_W'(1)));

    p_stamp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(ts_o));

endmodule

// File: rtl/dcp_addr_gen.sv
module dcp_addr_gen #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    logic [ADDR_W-1:0] addr_q;
    logic              wrap_q;

    assign addr_o = addr_q;
    assign wrap_o = wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wrap_q <= 1'b0;
        end else if (advance_i) begin
            addr_q <= addr_q + ADDR_W'(1);
            if (addr_q == ADDR_LAST)
                wrap_q <= 1'b1;
        end
    end

    // R9: once raised the wrap flag never drops before reset
    p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wrap_q));

    // R8: the address only moves when a word is written
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(addr_q));

endmodule

// File: rtl/delta_cluster_packer.sv
module delta_cluster_packer
    import dcp_pkg::*;
#(
    parameter int TS_W       = 16,
    parameter int ROW_W      = 15,
    parameter int CL_PER_ROW = 64
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   tick_i,
    input  logic [15:0]                                            sample_i,
    output logic                                                   wr_en_o,
    output logic [ROW_W+$clog2(CL_PER_ROW*WORDS_PER_CLUSTER)-1:0]  wr_addr_o,
    output logic [15:0]                                            wr_data_o,
    output logic                                                   wrap_o
);
    localparam int WORDS_PER_ROW = CL_PER_ROW * WORDS_PER_CLUSTER;
    localparam int WORD_W        = $clog2(WORDS_PER_ROW);
    localparam int ADDR_W        = ROW_W + WORD_W;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(EVENTS_PER_CLUSTER - 1);

    pk_state_e          state_q, state_d;
    logic [SLOT_W-1:0]  slot_q;
    logic [15:0]        pend_q;
    logic               want_open;
    logic               opened;
    logic               do_write;
    logic [15:0]        word_d;
    logic [TS_W-1:0]    ts_cur;
    logic [ADDR_W-1:0]  addr_cur;

    assign opened = (state_q == ST_IDLE) && want_open;

    dcp_change_det #(.GAP_W(TS_W)) u_change (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .sample_i    (sample_i),
        .opened_i    (opened),
        .want_open_o (want_open)
    );

    dcp_tick_stamp #(.TS_W(TS_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .ts_o   (ts_cur)
    );

    dcp_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (do_write),
        .addr_o    (addr_cur),
        .wrap_o    (wrap_o)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (want_open) state_d = ST_STAMP;
            ST_STAMP: state_d = ST_FILL;
            ST_FILL:  if (tick_i && slot_q == SLOT_LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Word selection for the current cycle
    always_comb begin
        do_write = 1'b0;
        word_d   = sample_i;
        unique case (state_q)
            ST_IDLE: begin
                if (want_open) begin
                    do_write = 1'b1;
                    word_d   = stamp_word(16'(ts_cur));
                end
            end
            ST_STAMP: begin
                do_write = 1'b1;
                word_d   = pend_q;
            end
            ST_FILL: begin
                if (tick_i) do_write = 1'b1;
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs and cluster bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= '0;
            pend_q    <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= do_write;
            if (do_write) begin
                wr_addr_o <= addr_cur;
                wr_data_o <= word_d;
            end
            if (opened)
                pend_q <= sample_i;
            if (state_q == ST_STAMP)
                slot_q <= SLOT_W'(1);
            else if (state_q == ST_FILL && tick_i)
                slot_q <= slot_q + SLOT_W'(1);
        end
    end

    // R10: no tick in the cycle straight after an opening tick
    p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAMP) |-> !tick_i);

    // R1: an opening puts the timestamp word on a cluster boundary
    p_cluster_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        opened |=> (wr_en_o && wr_addr_o[SLOT_W-1:0] == '0));

    // R2: the first event word follows the timestamp word without a gap
    p_stamp_then_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAMP) |=> (wr_en_o && wr_data_o == $past(pend_q)));

    // R6: a quiet idle cycle issues no write
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !want_open) |=> !wr_en_o);

    // R5: while filling, the slot count stays inside the event range
    p_fill_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (slot_q >= SLOT_W'(1) && slot_q <= SLOT_LAST));

    // R8: back-to-back writes use consecutive addresses
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (!wr_en_o || wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)));

endmodule

// File: tb/delta_cluster_packer_bench.sv
module delta_cluster_packer_bench;

    localparam int TS_W       = 5;
    localparam int ROW_W      = 1;
    localparam int CL_PER_ROW = 2;
    localparam int WORD_W     = 4;
    localparam int ADDR_W     = ROW_W + WORD_W;
    localparam int TOTAL      = 1 << ADDR_W;
    localparam int GAP_LIMIT  = (1 << TS_W) - 1;

    typedef struct {
        int                cyc;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [15:0]       sample = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic              wrap;

    int   vectors = 0;
    int   miscompares = 0;
    int   cyc = 0;
    int   writes_seen = 0;
    bit   obs_on = 1'b0;
    bit   done = 1'b0;
    exp_t expq[$];
    exp_t obs_e;

    // Reference model state
    int          m_ts = 0;
    logic [15:0] m_prev = '0;
    int          m_gap = GAP_LIMIT;
    bit          m_open = 1'b0;
    int          m_slot = 0;
    int          m_addr = 0;

    delta_cluster_packer #(
        .TS_W       (TS_W),
        .ROW_W      (ROW_W),
        .CL_PER_ROW (CL_PER_ROW)
    ) u_delta_cluster_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .sample_i  (sample),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .wrap_o    (wrap)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input logic [15:0] d, input string tag);
        exp_t e;
        e.cyc  = at;
        e.addr = ADDR_W'(m_addr);
        e.data = d;
        e.tag  = tag;
        expq.push_back(e);
        m_addr = (m_addr + 1) % TOTAL;
    endtask

    // Expected writes derived from R2, R3, R5, R7 and R8
    task automatic model_tick(input logic [15:0] s);
        logic [15:0] ts16;
        bit          want;
        ts16 = 16'(m_ts % (1 << TS_W));
        m_ts = m_ts + 1;
        want = (s != m_prev) || (m_gap == GAP_LIMIT);
        if (!m_open && want) begin
            push(cyc + 1, {ts16[7:0], ts16[15:8]}, (s == m_prev) ? "R7 R3 R1" : "R3 R1");
            push(cyc + 2, s, "R2 R4");
            m_open = 1'b1;
            m_slot = 1;
            m_gap  = 1;
        end else begin
            if (m_open) begin
                push(cyc + 1, s, "R5 R4");
                m_slot = m_slot + 1;
                if (m_slot == 7) m_open = 1'b0;
            end
            if (m_gap != GAP_LIMIT) m_gap = m_gap + 1;
        end
        m_prev = s;
    endtask

    task automatic send(input logic [15:0] s, input int idle);
        @(negedge clk);
        tick   = 1'b1;
        sample = s;
        model_tick(s);
        @(negedge clk);
        tick = 1'b0;
        repeat (idle - 1) @(negedge clk);
    endtask

    task automatic drain_check(input string tag);
        repeat (4) @(negedge clk);
        vectors++;
        if (expq.size() != 0) begin
            miscompares++;
            $display("FAIL %s: %0d expected writes still outstanding, expected 0", tag, expq.size());
            expq.delete();
        end
    endtask

    // Observer: compares every write against the expected schedule
    always @(negedge clk) begin
        if (obs_on) begin
            if (wr_en) begin
                writes_seen++;
                if (expq.size() == 0 || expq[0].cyc != cyc) begin
                    vectors++;
                    miscompares++;
                    $display("FAIL R6: write data %h addr %0d at cycle %0d, expected no write",
                             wr_data, wr_addr, cyc);
                end else begin
                    obs_e = expq.pop_front();
                    vectors++;
                    if (wr_data !== obs_e.data) begin
                        miscompares++;
                        $display("FAIL %s: data %h, expected %h", obs_e.tag, wr_data, obs_e.data);
                    end
                    vectors++;
                    if (wr_addr !== obs_e.addr) begin
                        miscompares++;
                        $display("FAIL R8: address %0d, expected %0d", wr_addr, obs_e.addr);
                    end
                end
            end else if (expq.size() > 0 && expq[0].cyc <= cyc) begin
                obs_e = expq.pop_front();
                vectors++;
                miscompares++;
                $display("FAIL %s: no write, expected data %h at address %0d",
                         obs_e.tag, obs_e.data, obs_e.addr);
            end
            vectors++;
            if (wrap !== (writes_seen >= TOTAL)) begin
                miscompares++;
                $display("FAIL R9: wrap %0b, expected %0b", wrap, writes_seen >= TOTAL);
            end
        end
    end

    initial begin
        logic [15:0] lf;
        logic [15:0] cur;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R8 and R9
        vectors++;
        if (wr_en !== 1'b0 || wr_addr !== '0 || wrap !== 1'b0) begin
            miscompares++;
            $display("FAIL R8 R9: reset en %0b addr %0d wrap %0b, expected 0 0 0",
                     wr_en, wr_addr, wrap);
        end
        obs_on = 1'b1;

        // R7: constant zero input, first tick and forced clusters only
        for (int i = 0; i < 70; i++) send(16'h0000, 1);
        drain_check("R7");

        // R4, R10: walking one at minimum tick spacing
        for (int i = 0; i < 16; i++) send(16'h0001 << i, 1);
        for (int i = 0; i < 16; i++) send(~(16'h0001 << i), 1);
        drain_check("R10");

        // R6: long stable runs between single changes
        cur = 16'hA5C3;
        for (int k = 0; k < 5; k++) begin
            cur = cur ^ 16'h8001;
            send(cur, 2);
            for (int i = 0; i < 45; i++) send(cur, 1 + (i % 3));
        end
        drain_check("R6");

        // R1, R2, R5: pseudo-random sweep with mixed spacing
        lf  = 16'hACE1;
        cur = 16'h1234;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[1:0] == 2'b00) cur = cur ^ {lf[15:2], 2'b01};
            send(cur, 1 + int'(lf[5:4]));
        end
        drain_check("R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule